// File: doc/BRIEF.md
# Endpoint Transmit Packet Buffer

This block holds the outgoing data of one USB device IN endpoint. The CPU side streams bytes into a region of a shared packet RAM and then closes each packet with a commit strobe. The serial engine side sees a flag for a ready packet and that packet's length. It reads the bytes one by one through a read address into the same RAM. When the host has taken the packet, the engine acknowledges it and the packet is freed. When the host must see the packet again, the engine asks for a retry, which moves the read position back to the packet's first byte.

The buffer counts whole packets, not bytes. In single mode it accepts one committed packet, even when that packet is far smaller than the region. In double mode it accepts two. A programmable maximum packet size caps each packet. A start address and a size place the region inside the RAM, and both addresses wrap within that region. A flush input empties the buffer in one cycle. A configuration error output reports a maximum packet size that the region cannot hold in the current mode.

Top module: `ep_tx_pktbuf`

## Requirements
- R1: After reset `eng_avail` and `full` are 0, `ovf_cnt` is 0, `mps_err` is 0 and `mps_q` equals the parameter `MPS_RST` (64 by default).
- R2: The bytes of committed packets are presented in order, oldest packet first. `eng_len` equals the number of bytes stored in the oldest packet, including a byte written in the same cycle as the commit.
- R3: With `cfg_dbl` = 0, `full` rises once one packet is committed. While `full` is 1, each `cpu_wr` stores nothing and adds one to `ovf_cnt`.
- R4: With `cfg_dbl` = 1, `full` stays 0 after the first commit and rises after the second.
- R5: A byte written while the open packet already holds `mps_q` bytes is dropped and adds one to `ovf_cnt`. The packet's length is capped at `mps_q`.
- R6: `cfg_err` is 1 when `mps_q` > `cfg_size`, or when `cfg_dbl` = 1 and 2·`mps_q` > `cfg_size`. Otherwise it is 0.
- R7: A `mps_wr` made while a packet is committed or open leaves `mps_q` unchanged and sets the sticky `mps_err`. A write made while the buffer is empty shows on `mps_q` one cycle later.
- R8: `eng_ack` frees the oldest packet. `eng_retry` sets `ram_raddr` back to that packet's first byte and keeps the packet.
- R9: `flush` drops all packets, including any open one. In the next cycle `eng_avail` is 0 and both addresses equal `cfg_start`.
- R10: Both addresses step from `cfg_start + cfg_size - 1` back to `cfg_start`.
- R11: A commit and an acknowledge in the same cycle leave the packet count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dbl | input | 1 | 1 selects two-packet buffering, 0 selects one-packet buffering |
| cfg_start | input | ADDR_W | First RAM address of the region |
| cfg_size | input | SIZE_W | Region size in bytes |
| cfg_err | output | 1 | Maximum packet size does not fit the region in the current mode |
| mps_wr | input | 1 | Write strobe for the maximum packet size |
| mps_wdata | input | SIZE_W | New maximum packet size |
| mps_q | output | SIZE_W | Current maximum packet size |
| mps_err | output | 1 | Sticky flag for a maximum-size write refused while data was held |
| cpu_wr | input | 1 | Byte write strobe from the CPU side |
| cpu_wdata | input | DATA_W | Byte to store |
| cpu_commit | input | 1 | Closes the open packet |
| flush | input | 1 | Empties the buffer and resets the pointers |
| full | output | 1 | Committed packets equal the mode's capacity |
| ovf_cnt | output | OVF_W | Count of dropped byte writes |
| eng_avail | output | 1 | At least one committed packet is waiting |
| eng_len | output | SIZE_W | Length of the oldest committed packet |
| eng_rd | input | 1 | Engine consumed the byte at `ram_raddr` |
| eng_ack | input | 1 | Oldest packet delivered, free it |
| eng_retry | input | 1 | Rewind to the oldest packet's first byte |
| ram_we | output | 1 | Packet RAM write enable |
| ram_waddr | output | ADDR_W | Packet RAM write address |
| ram_wdata | output | DATA_W | Packet RAM write data |
| ram_raddr | output | ADDR_W | Packet RAM read address for the engine |

## Verification
The CPU commit of a new packet and the engine acknowledge of the oldest one can land in the same cycle. The queue of lengths is then pushed and popped together, and the packet count must hold. The bench commits packet X in double mode, writes the bytes of packet Y and reads all of X. It then raises `cpu_commit` and `eng_ack` in one cycle. It expects exactly one packet to remain, with `full` low and `eng_len` equal to Y's length. The scoreboard then confirms that Y's bytes come out at the right addresses.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
   // Outcome of one CPU byte write.
   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_STORE = 2'd1,
      WR_DROP  = 2'd2
   } wr_verdict_e;
endpackage

// File: rtl/ep_tx_ring_ptr.sv
// Offset pointer inside a region of programmable size; wraps to zero.
module ep_tx_ring_ptr #(
   parameter int OFF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             load,
   input  logic [OFF_W-1:0] load_val,
   input  logic [OFF_W-1:0] size,
   output logic [OFF_W-1:0] off
);
   logic [OFF_W-1:0] step;

   always_comb begin
      step = off + OFF_W'(1);
      if (step == size) step = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    off <= '0;
      else if (clr)  off <= '0;
      else if (load) off <= load_val;
      else if (inc)  off <= step;
   end

   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !load && size != '0 && off == size - OFF_W'(1)) |=> (off == '0));
endmodule

// File: rtl/ep_tx_lenq.sv
// Small circular queue of committed packet lengths.
module ep_tx_lenq #(
   parameter int LEN_W = 11,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic                       pop,
   input  logic [LEN_W-1:0]           push_len,
   output logic [LEN_W-1:0]           head,
   output logic [$clog2(DEPTH+1)-1:0] cnt
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ep_tx_lenq: DEPTH must be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] slot [DEPTH];
   logic [IW-1:0]    wp, rp;

   function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
      return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
   endfunction

   assign head = slot[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) begin
            slot[wp] <= push_len;
            wp       <= nxt(wp);
         end
         if (pop) rp <= nxt(rp);
         if (push && !pop)      cnt <= cnt + CW'(1);
         else if (pop && !push) cnt <= cnt - CW'(1);
      end
   end

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !clr) |=> (cnt == $past(cnt)));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/ep_tx_pktbuf.sv
module ep_tx_pktbuf
   import ep_tx_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int SIZE_W  = 11,
   parameter int DATA_W  = 8,
   parameter int OVF_W   = 8,
   parameter int MPS_RST = 64,
   parameter bit OVF_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dbl,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [SIZE_W-1:0] cfg_size,
   output logic              cfg_err,
   input  logic              mps_wr,
   input  logic [SIZE_W-1:0] mps_wdata,
   output logic [SIZE_W-1:0] mps_q,
   output logic              mps_err,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_commit,
   input  logic              flush,
   output logic              full,
   output logic [OVF_W-1:0]  ovf_cnt,
   output logic              eng_avail,
   output logic [SIZE_W-1:0] eng_len,
   input  logic              eng_rd,
   input  logic              eng_ack,
   input  logic              eng_retry,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_waddr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic [ADDR_W-1:0] ram_raddr
);
   localparam int PKT_DEPTH = 2;
   localparam int CW        = $clog2(PKT_DEPTH + 1);

   generate
      if (SIZE_W < 10) begin : g_chk_size
         $error("ep_tx_pktbuf: SIZE_W must hold 1023");
      end
      if (ADDR_W > 16) begin : g_chk_addr
         $error("ep_tx_pktbuf: ADDR_W too large");
      end
      if (MPS_RST >= (1 << SIZE_W)) begin : g_chk_mps
         $error("ep_tx_pktbuf: MPS_RST does not fit SIZE_W");
      end
   endgenerate

   logic [CW-1:0]     pkt_cnt;
   logic [CW-1:0]     cap;
   logic [SIZE_W-1:0] open_len;
   logic [SIZE_W-1:0] wr_off, rd_off, base_off, next_base;
   logic [SIZE_W:0]   base_sum;
   logic              push, pop, rewind, holds;
   wr_verdict_e       verdict;

   // Capacity and flags
   assign cap       = cfg_dbl ? CW'(2) : CW'(1);
   assign full      = (pkt_cnt == cap);
   assign eng_avail = (pkt_cnt != '0);
   assign holds     = eng_avail || (open_len != '0);

   // Byte write decision
   always_comb begin
      verdict = WR_IDLE;
      if (cpu_wr) begin
         if (full || open_len >= mps_q) verdict = WR_DROP;
         else                           verdict = WR_STORE;
      end
   end

   assign ram_we    = (verdict == WR_STORE) && !flush;
   assign ram_wdata = cpu_wdata;
   assign ram_waddr = cfg_start + ADDR_W'(wr_off);
   assign ram_raddr = cfg_start + ADDR_W'(rd_off);

   assign push   = cpu_commit && !full && !flush;
   assign pop    = eng_ack && eng_avail && !flush;
   assign rewind = eng_retry && eng_avail && !flush;

   // Start of the packet after the oldest one
   always_comb begin
      base_sum = {1'b0, base_off} + {1'b0, eng_len};
      if (base_sum >= {1'b0, cfg_size}) base_sum = base_sum - {1'b0, cfg_size};
      next_base = base_sum[SIZE_W-1:0];
   end

   // Configuration check
   assign cfg_err = ({1'b0, mps_q} > {1'b0, cfg_size}) ||
                    (cfg_dbl && ({mps_q, 1'b0} > {1'b0, cfg_size}));

   ep_tx_lenq #(.LEN_W(SIZE_W), .DEPTH(PKT_DEPTH)) u_lenq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .push     (push),
      .pop      (pop),
      .push_len (open_len + ((verdict == WR_STORE) ? SIZE_W'(1) : SIZE_W'(0))),
      .head     (eng_len),
      .cnt      (pkt_cnt)
   );

   ep_tx_ring_ptr #(.OFF_W(SIZE_W)) u_wr_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .inc      (verdict == WR_STORE),
      .load     (1'b0),
      .load_val ('0),
      .size     (cfg_size),
      .off      (wr_off)
   );

   ep_tx_ring_ptr #(.OFF_W(SIZE_W)) u_rd_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .inc      (eng_rd && eng_avail),
      .load     (pop || rewind),
      .load_val (pop ? next_base : base_off),
      .size     (cfg_size),
      .off      (rd_off)
   );

   ep_tx_ring_ptr #(.OFF_W(SIZE_W)) u_base_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .inc      (1'b0),
      .load     (pop),
      .load_val (next_base),
      .size     (cfg_size),
      .off      (base_off)
   );

   // Open packet length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    open_len <= '0;
      else if (flush || push)        open_len <= '0;
      else if (verdict == WR_STORE)  open_len <= open_len + SIZE_W'(1);
   end

   // Maximum packet size register with refusal while data is held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mps_q   <= SIZE_W'(MPS_RST);
         mps_err <= 1'b0;
      end else if (mps_wr) begin
         if (holds) mps_err <= 1'b1;
         else       mps_q   <= mps_wdata;
      end
   end

   // Dropped-write counter: saturating or wrapping
   generate
      if (OVF_SAT) begin : g_ovf_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovf_cnt <= '0;
            else if (verdict == WR_DROP && !flush && ovf_cnt != '1)
               ovf_cnt <= ovf_cnt + OVF_W'(1);
         end
      end else begin : g_ovf_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovf_cnt <= '0;
            else if (verdict == WR_DROP && !flush)
               ovf_cnt <= ovf_cnt + OVF_W'(1);
         end
      end
   endgenerate

   p_full_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ram_we);
   p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && full && !flush && ovf_cnt != '1) |=> (ovf_cnt == $past(ovf_cnt) + OVF_W'(1)));
   p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (open_len < mps_q));
   p_mps_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mps_wr && eng_avail) |=> ($stable(mps_q) && mps_err));
   p_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_retry && !eng_ack && eng_avail && !flush) |=> (rd_off == $past(base_off)));
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!eng_avail && wr_off == '0 && rd_off == '0));
endmodule

// File: tb/sim_ep_tx_pktbuf.sv
module sim_ep_tx_pktbuf;
   localparam int AW = 10;
   localparam int SW = 11;
   localparam int DW = 8;
   localparam int OW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_dbl = 1'b0;
   logic [AW-1:0] cfg_start = 10'd256;
   logic [SW-1:0] cfg_size = 11'd128;
   logic          cfg_err;
   logic          mps_wr = 1'b0;
   logic [SW-1:0] mps_wdata = '0;
   logic [SW-1:0] mps_q;
   logic          mps_err;
   logic          cpu_wr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_commit = 1'b0;
   logic          flush = 1'b0;
   logic          full;
   logic [OW-1:0] ovf_cnt;
   logic          eng_avail;
   logic [SW-1:0] eng_len;
   logic          eng_rd = 1'b0;
   logic          eng_ack = 1'b0;
   logic          eng_retry = 1'b0;
   logic          ram_we;
   logic [AW-1:0] ram_waddr, ram_raddr;
   logic [DW-1:0] ram_wdata;

   always #4 clk = ~clk;

   ep_tx_pktbuf u0 (.*);

   // Packet RAM model
   logic [DW-1:0] mem [1 << AW];
   always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;

   // Scoreboard: entries are {address, data}
   logic [AW+DW-1:0] q[$];
   logic [AW+DW-1:0] saved[$];
   int checks = 0, errors = 0;
   int mchecks = 0, merrors = 0;
   int woff = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops and compares every byte the engine consumes (R2, R10)
   always @(posedge clk) begin
      if (rst_n && eng_rd && eng_avail) begin
         mchecks++;
         if (q.size() == 0) begin
            merrors++;
            $display("FAIL R2 actual read at %0d expected no read", ram_raddr);
         end else begin
            logic [AW+DW-1:0] e;
            e = q.pop_front();
            if (ram_raddr != e[AW+DW-1:DW] || mem[ram_raddr] != e[DW-1:0]) begin
               merrors++;
               $display("FAIL R2/R10 actual addr %0d data %0d expected addr %0d data %0d",
                        ram_raddr, mem[ram_raddr], e[AW+DW-1:DW], e[DW-1:0]);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Driver: writes n bytes, of which the first 'keep' are expected to be stored
   task automatic wr_bytes(input int n, input int keep, input int seed);
      for (int i = 0; i < n; i++) begin
         cpu_wr    = 1'b1;
         cpu_wdata = DW'(seed + i);
         if (i < keep) begin
            q.push_back({AW'(int'(cfg_start) + woff), DW'(seed + i)});
            woff = (woff + 1 == int'(cfg_size)) ? 0 : woff + 1;
         end
         tick();
      end
      cpu_wr = 1'b0;
   endtask

   task automatic commit();
      cpu_commit = 1'b1; tick(); cpu_commit = 1'b0;
   endtask

   task automatic rd_n(input int n);
      eng_rd = 1'b1;
      repeat (n) tick();
      eng_rd = 1'b0;
   endtask

   task automatic ack();
      eng_ack = 1'b1; tick(); eng_ack = 1'b0;
   endtask

   task automatic set_mps(input int v);
      mps_wr = 1'b1; mps_wdata = SW'(v); tick(); mps_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 eng_avail", eng_avail, 0);
      chk("R1 full", full, 0);
      chk("R1 ovf_cnt", ovf_cnt, 0);
      chk("R1 mps_q", mps_q, 64);
      chk("R1 mps_err", mps_err, 0);

      // R3 single mode: one packet fills the buffer
      wr_bytes(5, 5, 8'h10);
      commit();
      chk("R3 full", full, 1);
      chk("R2 eng_len", eng_len, 5);
      wr_bytes(1, 0, 8'hEE);
      chk("R3 ovf_cnt", ovf_cnt, 1);
      rd_n(5);
      chk("R2 drained", q.size(), 0);
      ack();
      chk("R8 freed", eng_avail, 0);

      // R4 double mode: two packets
      cfg_dbl = 1'b1;
      wr_bytes(3, 3, 8'h20);
      commit();
      chk("R4 not full after one", full, 0);
      wr_bytes(4, 4, 8'h30);
      commit();
      chk("R4 full after two", full, 1);
      chk("R2 oldest len", eng_len, 3);
      rd_n(3); ack();
      chk("R8 next len", eng_len, 4);
      chk("R4 full after ack", full, 0);
      rd_n(4); ack();
      chk("R8 empty", eng_avail, 0);

      // R7 write accepted while empty; R5 cap at mps
      set_mps(4);
      chk("R7 mps accepted", mps_q, 4);
      wr_bytes(6, 4, 8'h40);
      chk("R5 ovf_cnt", ovf_cnt, 3);
      commit();
      chk("R5 len capped", eng_len, 4);
      rd_n(4); ack();

      // R7 refused while an open packet exists
      wr_bytes(1, 1, 8'h50);
      set_mps(8);
      chk("R7 mps held", mps_q, 4);
      chk("R7 mps_err", mps_err, 1);
      commit(); rd_n(1); ack();
      set_mps(64);
      chk("R7 mps after empty", mps_q, 64);
      chk("R7 mps_err sticky", mps_err, 1);

      // R6 configuration check
      cfg_size = 11'd100; #1;
      chk("R6 double too small", cfg_err, 1);
      cfg_dbl = 1'b0; #1;
      chk("R6 single fits", cfg_err, 0);
      cfg_size = 11'd50; #1;
      chk("R6 single too small", cfg_err, 1);
      cfg_size = 11'd128; cfg_dbl = 1'b1; #1;
      chk("R6 double fits", cfg_err, 0);

      // R8 retry (oldest packet starts at offset 17)
      wr_bytes(6, 6, 8'h60);
      commit();
      saved = q;
      rd_n(2);
      eng_retry = 1'b1; tick(); eng_retry = 1'b0;
      chk("R8 rewind addr", ram_raddr, 256 + 17);
      chk("R8 still held", eng_avail, 1);
      q = saved;
      rd_n(6); ack();

      // R11 commit and acknowledge in one cycle
      wr_bytes(3, 3, 8'h70);
      commit();
      wr_bytes(2, 2, 8'h80);
      rd_n(3);
      cpu_commit = 1'b1; eng_ack = 1'b1; tick();
      cpu_commit = 1'b0; eng_ack = 1'b0;
      chk("R11 one left", eng_avail, 1);
      chk("R11 not full", full, 0);
      chk("R11 len", eng_len, 2);
      rd_n(2); ack();

      // R9 flush
      wr_bytes(2, 2, 8'h90);
      commit();
      wr_bytes(1, 1, 8'h95);
      flush = 1'b1; tick(); flush = 1'b0;
      chk("R9 empty", eng_avail, 0);
      chk("R9 raddr", ram_raddr, 256);
      chk("R9 waddr", ram_waddr, 256);
      q.delete(); woff = 0;
      wr_bytes(1, 1, 8'hA0);
      commit(); rd_n(1); ack();

      // R10 wrap in a 16-byte region
      flush = 1'b1; tick(); flush = 1'b0;
      woff = 0;
      cfg_size = 11'd16; cfg_dbl = 1'b0;
      set_mps(10);
      chk("R6 small region fits", cfg_err, 0);
      wr_bytes(10, 10, 8'hB0);
      commit(); rd_n(10); ack();
      wr_bytes(10, 10, 8'hC0);
      commit(); rd_n(10); ack();
      chk("R10 raddr after wrap", ram_raddr, 256 + 4);
      chk("R2 all consumed", q.size(), 0);

      tick();
      finish_run();
   end
endmodule